// File: doc/BRIEF.md
# Header-Chained Register Program Engine

This block fetches register-write programs from memory and replays them onto a register-write port, with no CPU work per write. Software gives it the memory address of a header. The header names up to eight bodies, and each body is a run of 8-byte entries, each an address word followed by a data word. The engine reads each entry and presents one register write per entry. It holds each write until the target accepts it.

The header's flags word decides what happens when its last body is done. With auto-start set, the engine follows the header's next-header link and runs that header too, so a chain of headers completes without software help. With interrupt-enable set on the final header only, a whole chain produces exactly one completion pulse.

The controller has ten named states:
- `ST_IDLE` waits for a start write.
- `ST_HDR_COUNT`, `ST_HDR_NEXT` and `ST_HDR_FLAGS` read the header's count, link and flags words.
- `ST_SLOT_LEN` and `ST_SLOT_ADDR` read one slot.
- `ST_ENT_ADDR` and `ST_ENT_DATA` read one entry.
- `ST_WRITE` waits for the write to be accepted.
- `ST_FINISH` either follows the link or ends the run.

The transitions are:
- start: `ST_IDLE` → `ST_HDR_COUNT`.
- header reads: `ST_HDR_COUNT` → `ST_HDR_NEXT` → `ST_HDR_FLAGS` → `ST_SLOT_LEN`.
- slot with entries: `ST_SLOT_LEN` → `ST_SLOT_ADDR` → `ST_ENT_ADDR`.
- empty slot: `ST_SLOT_LEN` → `ST_SLOT_LEN`, or to `ST_FINISH` if it was the last slot.
- entry: `ST_ENT_ADDR` → `ST_ENT_DATA` → `ST_WRITE`.
- after a write: `ST_WRITE` → `ST_ENT_ADDR` (more entries), `ST_SLOT_LEN` (next slot) or `ST_FINISH`.
- chain: `ST_FINISH` → `ST_HDR_COUNT`.
- stop: `ST_FINISH` → `ST_IDLE`.

Top module: `dlist_engine`

## Requirements
- R1: A start write while idle makes `busy` high in the next cycle. In that same cycle the engine presents a memory read of the given header address.
- R2: A start write while `busy` is high is ignored. The header at the address it carries is never read, and none of its writes occur.
- R3: Header layout, as byte offsets from the header address:
  - +0: count word. The number of slots run is count+1; a count above 7 runs all 8 slots.
  - +4+8i: slot i byte count.
  - +8+8i: slot i body address.
  - +68: next-header address.
  - +72: flags word.
- R4: Entry k of a body has its register address at body+8k and its data at body+8k+4. Writes go out in slot order, and in ascending entry order within a slot.
- R5: A slot runs byte count / 8 entries. A slot with zero entries issues no writes, and its body address word is never read.
- R6: `reg_wr_valid` stays high, with address and data stable, until `reg_wr_ready` is seen.
- R7: `mem_req_valid` stays high, with its address stable, until `mem_req_ready` is seen. No memory read is requested while idle.
- R8: Flags bit 0 (auto-start) makes the engine run the header at the next-header address once the current header's bodies are done. It takes precedence over bit 1.
- R9: Flags bit 1 (interrupt enable) with bit 0 clear raises `irq` for exactly one cycle, in the cycle `busy` falls. A chain therefore gives one pulse.
- R10: A header whose flags have both bits clear ends the run without `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Write strobe for the header-address register |
| cfg_start_addr | input | 32 | Header address written with the strobe |
| busy | output | 1 | High while a program runs |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 32 | Memory read byte address |
| mem_rsp_valid | input | 1 | Read response valid (single beat) |
| mem_rsp_data | input | 32 | Read response data |
| reg_wr_valid | output | 1 | Register write valid |
| reg_wr_ready | input | 1 | Register write accepted |
| reg_wr_addr | output | 32 | Register write address |
| reg_wr_data | output | 32 | Register write data |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions check, on every cycle:
- that read requests and register writes hold stable under back-pressure;
- that no read or write leaves the block while it is idle;
- that a completion pulse lasts one cycle and coincides with `busy` falling;
- that the controller never hands the reader a new address while a read is still open.

Only the bench scenarios can show the rest:
- the header offsets, and slot and entry ordering;
- skipping of empty slots, and clamping of the slot count;
- chain following, with a single interrupt for the whole chain;
- that a start written while busy is ignored.

// File: rtl/dle_pkg.sv
package dle_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR_COUNT,
        ST_HDR_NEXT,
        ST_HDR_FLAGS,
        ST_SLOT_LEN,
        ST_SLOT_ADDR,
        ST_ENT_ADDR,
        ST_ENT_DATA,
        ST_WRITE,
        ST_FINISH
    } eng_state_e;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_REQ,
        RD_WAIT
    } rd_state_e;

    localparam int FLAG_AUTO = 0;
    localparam int FLAG_IRQ  = 1;

endpackage

// File: rtl/dle_mem_reader.sv
module dle_mem_reader
    import dle_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] go_addr,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data
);

    rd_state_e     st;
    logic [AW-1:0] addr_q;
    logic          free;

    assign done          = (st == RD_WAIT) && mem_rsp_valid;
    assign free          = (st == RD_IDLE) || done;
    assign rdata         = mem_rsp_data;
    assign mem_req_valid = (st == RD_REQ);
    assign mem_req_addr  = addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= RD_IDLE;
            addr_q <= '0;
        end else begin
            unique case (st)
                RD_IDLE: if (go) begin
                    st     <= RD_REQ;
                    addr_q <= go_addr;
                end
                RD_REQ: if (mem_req_ready) st <= RD_WAIT;
                RD_WAIT: if (mem_rsp_valid) begin
                    if (go) begin
                        st     <= RD_REQ;
                        addr_q <= go_addr;
                    end else begin
                        st <= RD_IDLE;
                    end
                end
                default: st <= RD_IDLE;
            endcase
        end
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R7
    go_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> free);

endmodule

// File: rtl/dle_reg_writer.sv
module dle_reg_writer #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] go_addr,
    input  logic [DW-1:0] go_data,
    output logic          done,
    output logic          reg_wr_valid,
    input  logic          reg_wr_ready,
    output logic [AW-1:0] reg_wr_addr,
    output logic [DW-1:0] reg_wr_data
);

    logic          valid_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    assign done         = valid_q && reg_wr_ready;
    assign reg_wr_valid = valid_q;
    assign reg_wr_addr  = addr_q;
    assign reg_wr_data  = data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else if (go) begin
            valid_q <= 1'b1;
            addr_q  <= go_addr;
            data_q  <= go_data;
        end else if (done) begin
            valid_q <= 1'b0;
        end
    end

    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_valid && !reg_wr_ready |=> reg_wr_valid && $stable(reg_wr_addr) && $stable(reg_wr_data));

    // R6
    wr_go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !reg_wr_valid);

endmodule

// File: rtl/dlist_engine.sv
module dlist_engine
    import dle_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int SLOTS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_start,
    input  logic [31:0]   cfg_start_addr,
    output logic          busy,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [31:0]   mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [31:0]   mem_rsp_data,
    output logic          reg_wr_valid,
    input  logic          reg_wr_ready,
    output logic [31:0]   reg_wr_addr,
    output logic [31:0]   reg_wr_data,
    output logic          irq
);

    localparam int SLOT_W   = $clog2(SLOTS) + 1;
    localparam int ENT_W    = DW - 3;
    localparam int NEXT_OFF = 4 + 8 * SLOTS;
    localparam int FLAG_OFF = NEXT_OFF + 4;

    eng_state_e     st, st_n;
    logic [AW-1:0]  hdr_q, hdr_n, next_q, next_n, body_q, body_n, eaddr_q, eaddr_n;
    logic [1:0]     flags_q, flags_n;
    logic [SLOT_W-1:0] idx_q, idx_n, total_q, total_n;
    logic [ENT_W-1:0]  left_q, left_n;
    logic           irq_q;

    logic           rd_go, rd_done, wr_go, wr_done;
    logic [AW-1:0]  rd_addr;
    logic [DW-1:0]  rd_data;

    dle_mem_reader #(.AW(AW), .DW(DW)) u_rd (
        .clk(clk), .rst_n(rst_n), .go(rd_go), .go_addr(rd_addr),
        .done(rd_done), .rdata(rd_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    dle_reg_writer #(.AW(AW), .DW(DW)) u_wr (
        .clk(clk), .rst_n(rst_n), .go(wr_go), .go_addr(eaddr_q),
        .go_data(rd_data), .done(wr_done),
        .reg_wr_valid(reg_wr_valid), .reg_wr_ready(reg_wr_ready),
        .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data)
    );

    function automatic logic [AW-1:0] slot_len_at(input logic [AW-1:0] h, input logic [SLOT_W-1:0] i);
        return h + AW'(4) + AW'({i, 3'b000});
    endfunction

    always_comb begin
        st_n    = st;
        hdr_n   = hdr_q;
        next_n  = next_q;
        body_n  = body_q;
        eaddr_n = eaddr_q;
        flags_n = flags_q;
        idx_n   = idx_q;
        total_n = total_q;
        left_n  = left_q;
        rd_go   = 1'b0;
        rd_addr = '0;
        wr_go   = 1'b0;
        unique case (st)
            ST_IDLE: if (cfg_start) begin
                hdr_n   = cfg_start_addr;
                rd_go   = 1'b1;
                rd_addr = cfg_start_addr;
                st_n    = ST_HDR_COUNT;
            end
            ST_HDR_COUNT: if (rd_done) begin
                total_n = (rd_data > DW'(SLOTS - 1)) ? SLOT_W'(SLOTS)
                                                     : rd_data[SLOT_W-1:0] + 1'b1;
                rd_go   = 1'b1;
                rd_addr = hdr_q + AW'(NEXT_OFF);
                st_n    = ST_HDR_NEXT;
            end
            ST_HDR_NEXT: if (rd_done) begin
                next_n  = rd_data;
                rd_go   = 1'b1;
                rd_addr = hdr_q + AW'(FLAG_OFF);
                st_n    = ST_HDR_FLAGS;
            end
            ST_HDR_FLAGS: if (rd_done) begin
                flags_n = rd_data[1:0];
                idx_n   = '0;
                rd_go   = 1'b1;
                rd_addr = slot_len_at(hdr_q, '0);
                st_n    = ST_SLOT_LEN;
            end
            ST_SLOT_LEN: if (rd_done) begin
                left_n = rd_data[DW-1:3];
                if (rd_data[DW-1:3] != '0) begin
                    rd_go   = 1'b1;
                    rd_addr = slot_len_at(hdr_q, idx_q) + AW'(4);
                    st_n    = ST_SLOT_ADDR;
                end else if (idx_q + 1'b1 < total_q) begin
                    idx_n   = idx_q + 1'b1;
                    rd_go   = 1'b1;
                    rd_addr = slot_len_at(hdr_q, idx_q + 1'b1);
                    st_n    = ST_SLOT_LEN;
                end else begin
                    st_n = ST_FINISH;
                end
            end
            ST_SLOT_ADDR: if (rd_done) begin
                body_n  = rd_data;
                rd_go   = 1'b1;
                rd_addr = rd_data;
                st_n    = ST_ENT_ADDR;
            end
            ST_ENT_ADDR: if (rd_done) begin
                eaddr_n = rd_data;
                rd_go   = 1'b1;
                rd_addr = body_q + AW'(4);
                st_n    = ST_ENT_DATA;
            end
            ST_ENT_DATA: if (rd_done) begin
                wr_go  = 1'b1;
                body_n = body_q + AW'(8);
                left_n = left_q - 1'b1;
                st_n   = ST_WRITE;
            end
            ST_WRITE: if (wr_done) begin
                if (left_q != '0) begin
                    rd_go   = 1'b1;
                    rd_addr = body_q;
                    st_n    = ST_ENT_ADDR;
                end else if (idx_q + 1'b1 < total_q) begin
                    idx_n   = idx_q + 1'b1;
                    rd_go   = 1'b1;
                    rd_addr = slot_len_at(hdr_q, idx_q + 1'b1);
                    st_n    = ST_SLOT_LEN;
                end else begin
                    st_n = ST_FINISH;
                end
            end
            ST_FINISH: begin
                if (flags_q[FLAG_AUTO]) begin
                    hdr_n   = next_q;
                    rd_go   = 1'b1;
                    rd_addr = next_q;
                    st_n    = ST_HDR_COUNT;
                end else begin
                    st_n = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q   <= '0;
            next_q  <= '0;
            body_q  <= '0;
            eaddr_q <= '0;
            flags_q <= '0;
            idx_q   <= '0;
            total_q <= '0;
            left_q  <= '0;
            irq_q   <= 1'b0;
        end else begin
            hdr_q   <= hdr_n;
            next_q  <= next_n;
            body_q  <= body_n;
            eaddr_q <= eaddr_n;
            flags_q <= flags_n;
            idx_q   <= idx_n;
            total_q <= total_n;
            left_q  <= left_n;
            irq_q   <= (st == ST_FINISH) && !flags_q[FLAG_AUTO] && flags_q[FLAG_IRQ];
        end
    end

    assign busy = (st != ST_IDLE);
    assign irq  = irq_q;

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9
    irq_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $fell(busy));

    // R7
    idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid);

    // R6
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !reg_wr_valid);

endmodule

// File: tb/dlist_engine_bench.sv
`timescale 1ns/1ps
module dlist_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_start = 1'b0;
    logic [31:0] cfg_start_addr = '0;
    logic        busy, mem_req_valid, reg_wr_valid, irq;
    logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, reg_wr_ready = 1'b0;
    logic [31:0] mem_req_addr, reg_wr_addr, reg_wr_data;
    logic [31:0] mem_rsp_data = '0;

    always #2.5 clk = ~clk;

    dlist_engine u_dlist_engine (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_start_addr(cfg_start_addr),
        .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .reg_wr_valid(reg_wr_valid), .reg_wr_ready(reg_wr_ready), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .irq(irq)
    );

    typedef struct packed { logic [31:0] a; logic [31:0] d; } wr_t;
    wr_t expq[$];
    bit [31:0] mem [bit [31:0]];
    bit        seen [bit [31:0]];
    int n_chk = 0, n_fail = 0, n_irq = 0;
    int cyc = 0;

    // memory and target models
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_req_ready <= (cyc % 3) != 1;
        reg_wr_ready  <= (cyc % 4) != 2;
        mem_rsp_valid <= mem_req_valid && mem_req_ready;
        if (mem_req_valid && mem_req_ready) begin
            mem_rsp_data <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 32'h0;
            seen[mem_req_addr] = 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor (R4)
    always @(negedge clk) begin
        if (rst_n && irq) n_irq++;
        if (rst_n && reg_wr_valid && reg_wr_ready) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R4 unexpected write", {reg_wr_addr, reg_wr_data}, 64'h0);
            end else begin
                wr_t e;
                e = expq.pop_front();
                chk({reg_wr_addr, reg_wr_data} == {e.a, e.d}, "R4 write order",
                    {reg_wr_addr, reg_wr_data}, {e.a, e.d});
            end
        end
    end

    task automatic put_hdr(input [31:0] h, input [31:0] cnt, input [31:0] nxt, input [31:0] fl);
        mem[h] = cnt;
        mem[h + 68] = nxt;
        mem[h + 72] = fl;
    endtask

    task automatic put_slot(input [31:0] h, input int idx, input [31:0] body, input int n, input [31:0] tag);
        mem[h + 4 + 8 * idx] = n * 8;
        mem[h + 8 + 8 * idx] = body;
        for (int k = 0; k < n; k++) begin
            wr_t e;
            e.a = tag + 4 * k;
            e.d = {tag[15:0] ^ 16'h5a5a, 16'(k)};
            mem[body + 8 * k] = e.a;
            mem[body + 8 * k + 4] = e.d;
            expq.push_back(e);
        end
    endtask

    task automatic kick(input [31:0] h);
        @(negedge clk);
        cfg_start = 1'b1;
        cfg_start_addr = h;
        @(negedge clk);
        cfg_start = 1'b0;
        // R1: busy and first read of header address visible one cycle after start
        chk(busy == 1'b1, "R1 busy after start", 64'(busy), 64'h1);
        chk(mem_req_valid && mem_req_addr == h, "R1 first read addr", 64'(mem_req_addr), 64'(h));
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=busy expected=idle");
        finish_run();
    end

    initial begin
        int irq0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(!busy && !irq && !reg_wr_valid && !mem_req_valid, "R1 reset idle",
            {busy, irq, reg_wr_valid, mem_req_valid}, 64'h0);

        // single header, single body, interrupt (R3 R4 R9)
        put_hdr(32'h1000, 0, 32'h0, 32'h2);
        put_slot(32'h1000, 0, 32'h2000, 3, 32'hA000);
        irq0 = n_irq;
        kick(32'h1000);
        wait_idle();
        chk(expq.size() == 0, "R4 all writes seen", 64'(expq.size()), 64'h0);
        chk(n_irq - irq0 == 1, "R9 one irq", 64'(n_irq - irq0), 64'h1);

        // three slots, middle empty (R5)
        put_hdr(32'h3000, 2, 32'h0, 32'h2);
        put_slot(32'h3000, 0, 32'h3400, 2, 32'hB000);
        put_slot(32'h3000, 1, 32'h3800, 0, 32'hB100);
        put_slot(32'h3000, 2, 32'h3C00, 2, 32'hB200);
        kick(32'h3000);
        wait_idle();
        chk(expq.size() == 0, "R5 writes of non-empty slots", 64'(expq.size()), 64'h0);
        chk(!seen.exists(32'h3000 + 16), "R5 empty slot addr not read", 64'(seen.exists(32'h3000 + 16)), 64'h0);
        chk(seen.exists(32'h3000 + 72), "R3 flags word read at +72", 64'(seen.exists(32'h3000 + 72)), 64'h1);

        // chain: both bits on first (auto wins), irq only on last (R8 R9)
        put_hdr(32'h5000, 0, 32'h6000, 32'h3);
        put_slot(32'h5000, 0, 32'h5400, 2, 32'hC000);
        put_hdr(32'h6000, 1, 32'h0, 32'h2);
        put_slot(32'h6000, 0, 32'h6400, 1, 32'hC100);
        put_slot(32'h6000, 1, 32'h6800, 2, 32'hC200);
        irq0 = n_irq;
        kick(32'h5000);
        wait_idle();
        chk(expq.size() == 0, "R8 chained header executed", 64'(expq.size()), 64'h0);
        chk(n_irq - irq0 == 1, "R9 single irq for chain", 64'(n_irq - irq0), 64'h1);
        chk(seen.exists(32'h6000), "R8 next header fetched", 64'(seen.exists(32'h6000)), 64'h1);

        // no flags: no irq (R10)
        put_hdr(32'h7000, 0, 32'h0, 32'h0);
        put_slot(32'h7000, 0, 32'h7400, 2, 32'hD000);
        irq0 = n_irq;
        kick(32'h7000);
        wait_idle();
        chk(expq.size() == 0, "R10 writes done", 64'(expq.size()), 64'h0);
        chk(n_irq == irq0, "R10 no irq", 64'(n_irq - irq0), 64'h0);
        chk(!busy, "R10 back to idle", 64'(busy), 64'h0);

        // count clamped to eight slots (R3)
        put_hdr(32'h8000, 12, 32'h0, 32'h2);
        for (int s = 0; s < 8; s++) put_slot(32'h8000, s, 32'h8400 + 32'(s) * 32'h40, 1, 32'hE000 + 32'(s) * 32'h10);
        kick(32'h8000);
        wait_idle();
        chk(expq.size() == 0, "R3 eight slots run", 64'(expq.size()), 64'h0);

        // start while busy ignored (R2)
        put_hdr(32'h9000, 0, 32'h0, 32'h2);
        put_slot(32'h9000, 0, 32'h9400, 4, 32'hF000);
        mem[32'hA000] = 0;
        mem[32'hA000 + 72] = 2;
        kick(32'h9000);
        repeat (6) @(negedge clk);
        chk(busy, "R2 still busy at second start", 64'(busy), 64'h1);
        cfg_start = 1'b1;
        cfg_start_addr = 32'hA000;
        @(negedge clk);
        cfg_start = 1'b0;
        wait_idle();
        chk(expq.size() == 0, "R2 only first program ran", 64'(expq.size()), 64'h0);
        chk(!seen.exists(32'hA000), "R2 ignored header not read", 64'(seen.exists(32'hA000)), 64'h0);

        finish_run();
    end

endmodule